// File: doc/BRIEF.md
# Vector Gather-Scatter Lane Sequencer

This block carries out one indexed vector memory operation over a 128-bit vector register. A gather-load or a scatter-store is described by a handful of encoding fields. Each lane forms its own address as a scalar base plus an offset taken from an offset vector. When scaling is requested, that offset is first shifted left by the log2 of the memory access size. The sequencer visits lanes in ascending order and makes one access per cycle through a single-beat request/grant memory port. Load data comes back on a valid strobe.

Loads that read less than a lane are widened by sign or zero extension and merged into a destination copy. That copy is seeded from `data_i` when the operation starts and is returned on `result_o` with the completion pulse. Stores drive the low bits of each lane to memory. Lane activity is controlled by two masks: a per-byte predicate and a per-32-bit-beat enable. Doubleword mode runs as four 32-bit beats, and each pair of beats shares one offset. Encodings that are not allowed are rejected when the start pulse arrives, and no memory traffic follows.

Top module: `vgs_seq`

## Requirements
- R1: Size codes are 0=byte, 1=halfword, 2=word, 3=doubleword. With element size code E < 3 there are 16>>E lanes; with E=3 there are four 32-bit beats. Lane n occupies vector bytes n<<min(E,2) upward. Accesses are issued in ascending lane order, one per enabled lane, and none for other lanes.
- R2: A lane's address is `base_i` plus its offset, which is the lane's element of `offs_i` read as unsigned. When `scale_i` is 1, the offset is shifted left by the memory size code M before the add. The sum wraps at 32 bits.
- R3: On a load, the low (1<<min(M,2)) bytes of `mem_rdata_i` are zero-extended when `signed_i` is 0 and sign-extended when it is 1. The result is written into every byte of the lane.
- R4: A load lane whose predicate bit (`pred_i` at the lane's lowest byte index) is 0 is written with zero and makes no access.
- R5: A load lane whose beat-enable bit (`beat_en_i` at the lane's lowest byte index divided by 4) is 0 makes no access and keeps its `data_i` value. Stores ignore `beat_en_i`.
- R6: With E=M=3, beat b takes its offset from the 32-bit word at beat b with bit 0 cleared. Odd beats add 4 to the address. Each beat is gated by its own predicate bit `pred_i[4b]`, and every access is a 32-bit access.
- R7: A store drives `mem_wdata_o` with the lane value truncated to the memory size, upper bits zero. `mem_wstrb_o` has its low (1<<min(M,2)) bits set.
- R8: The encoding is illegal in any of these cases: M > E; exactly one of M and E equals 3; `signed_i` is 1 on a store or with M >= E; M=0 with scaling; a load with `dst_idx_i == off_idx_i`; `base_idx_i == 15`. An illegal operation raises `illegal_o` with `done_o` in the cycle after start, makes no access, and returns `data_i` unchanged.
- R9: A request holds its address and data until granted. After a granted load, no new request is made until `mem_rvalid_i` has returned the data.
- R10: `done_o` is a one-cycle pulse after the last lane. A start pulse that arrives while an operation is running is ignored. After reset, `done_o`, `illegal_o`, `mem_req_o` and `result_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch pulse, sampled only when idle |
| load_i | input | 1 | 1 = gather-load, 0 = scatter-store |
| signed_i | input | 1 | Sign-extend loaded data |
| scale_i | input | 1 | Shift offsets by memory size code |
| esize_i | input | 2 | Element size code |
| msize_i | input | 2 | Memory access size code |
| dst_idx_i | input | 3 | Destination vector register index |
| off_idx_i | input | 3 | Offset vector register index |
| base_idx_i | input | 4 | Scalar base register index |
| base_i | input | 32 | Scalar base address |
| offs_i | input | 128 | Offset vector |
| data_i | input | 128 | Store data, or old destination for loads |
| pred_i | input | 16 | Per-byte predicate |
| beat_en_i | input | 4 | Per-beat enable (loads only) |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Byte address |
| mem_wdata_o | output | 32 | Right-justified write data |
| mem_wstrb_o | output | 4 | Byte strobes, low-justified |
| mem_gnt_i | input | 1 | Request accepted this cycle |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Right-justified read data |
| done_o | output | 1 | Completion pulse |
| illegal_o | output | 1 | Encoding rejected, valid with done_o |
| result_o | output | 128 | Destination vector |

## Verification
The embedded assertions check the port protocol on every cycle. They cover requests that stay stable while stalled, the single outstanding load, the one-cycle completion pulse, and the immediate rejection of an illegal start. Lane ordering, address arithmetic, extension, zeroing versus keeping of masked lanes, the doubleword pairing and the store data shaping can only be shown by the bench's scenarios. There, a behavioural model predicts every access and the final vector for each mix of sizes, masks and scaling.

// File: rtl/vgs_pkg.sv
package vgs_pkg;
  localparam int unsigned VEC_BYTES  = 16;
  localparam int unsigned BEAT_BYTES = 4;
  localparam int unsigned ADDR_W     = 32;
  localparam int unsigned VEC_W      = VEC_BYTES * 8;
  localparam int unsigned BEAT_W     = BEAT_BYTES * 8;
  localparam int unsigned NBEATS     = VEC_BYTES / BEAT_BYTES;
  localparam int unsigned LANE_IW    = $clog2(VEC_BYTES);
  localparam int unsigned BEAT_SH    = $clog2(BEAT_BYTES);

  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2, SZ_D = 2'd3} size_e;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_DONE} state_e;
endpackage

// File: rtl/vgs_decode.sv
module vgs_decode
  import vgs_pkg::*;
(
  input  logic               load_i,
  input  logic               signed_i,
  input  logic               scale_i,
  input  logic [1:0]         esize_i,
  input  logic [1:0]         msize_i,
  input  logic [2:0]         dst_idx_i,
  input  logic [2:0]         off_idx_i,
  input  logic [3:0]         base_idx_i,
  output logic               illegal_o,
  output logic [LANE_IW-1:0] last_lane_o,
  output logic [1:0]         lane_sh_o,
  output logic [1:0]         acc_sh_o,
  output logic [1:0]         off_sh_o,
  output logic               pair_o
);
  size_e esz, msz;
  assign esz = size_e'(esize_i);
  assign msz = size_e'(msize_i);

  always_comb begin
    illegal_o = 1'b0;
    if (msz > esz)                              illegal_o = 1'b1;
    if ((msz == SZ_D) != (esz == SZ_D))         illegal_o = 1'b1;
    if (signed_i && (!load_i || msz >= esz))    illegal_o = 1'b1;
    if (scale_i && msz == SZ_B)                 illegal_o = 1'b1;
    if (load_i && dst_idx_i == off_idx_i)       illegal_o = 1'b1;
    if (base_idx_i == 4'hF)                     illegal_o = 1'b1;
  end

  // doubleword runs as word-sized beats
  assign pair_o      = (esz == SZ_D);
  assign lane_sh_o   = pair_o ? 2'(SZ_W) : esize_i;
  assign acc_sh_o    = (msz == SZ_D) ? 2'(SZ_W) : msize_i;
  assign off_sh_o    = scale_i ? msize_i : 2'd0;
  assign last_lane_o = LANE_IW'((VEC_BYTES >> lane_sh_o) - 1);
endmodule

// File: rtl/vgs_lane_sel.sv
module vgs_lane_sel
  import vgs_pkg::*;
(
  input  logic [LANE_IW-1:0]   lane_i,
  input  logic [1:0]           lane_sh_i,
  input  logic [1:0]           off_sh_i,
  input  logic                 pair_i,
  input  logic [ADDR_W-1:0]    base_i,
  input  logic [VEC_W-1:0]     offs_i,
  input  logic [VEC_W-1:0]     src_i,
  input  logic [VEC_BYTES-1:0] pred_i,
  input  logic [NBEATS-1:0]    beat_en_i,
  output logic [LANE_IW-1:0]   pos_o,
  output logic [ADDR_W-1:0]    addr_o,
  output logic                 pred_on_o,
  output logic                 beat_on_o,
  output logic [BEAT_W-1:0]    src_lane_o
);
  logic [LANE_IW-1:0] off_pos;
  logic [VEC_W-1:0]   off_shr, src_shr;
  logic [BEAT_W-1:0]  lane_mask, off_val;
  logic [ADDR_W-1:0]  pair_add;

  assign pos_o     = lane_i << lane_sh_i;
  // odd doubleword beats reuse the even beat's offset
  assign off_pos   = pair_i ? (pos_o & ~LANE_IW'(BEAT_BYTES)) : pos_o;
  assign lane_mask = ~({BEAT_W{1'b1}} << (6'd8 << lane_sh_i));
  assign off_shr   = offs_i >> {off_pos, 3'b000};
  assign src_shr   = src_i >> {pos_o, 3'b000};
  assign off_val   = off_shr[BEAT_W-1:0] & lane_mask;
  assign src_lane_o = src_shr[BEAT_W-1:0] & lane_mask;
  assign pair_add  = (pair_i && pos_o[BEAT_SH]) ? ADDR_W'(BEAT_BYTES) : '0;
  assign addr_o    = base_i + (ADDR_W'(off_val) << off_sh_i) + pair_add;
  assign pred_on_o = pred_i[pos_o];
  assign beat_on_o = beat_en_i[pos_o[LANE_IW-1:BEAT_SH]];
endmodule

// File: rtl/vgs_access_fmt.sv
module vgs_access_fmt
  import vgs_pkg::*;
(
  input  logic [1:0]            acc_sh_i,
  input  logic                  signed_i,
  input  logic [BEAT_W-1:0]     src_lane_i,
  input  logic [BEAT_W-1:0]     rdata_i,
  output logic [BEAT_W-1:0]     wdata_o,
  output logic [BEAT_BYTES-1:0] wstrb_o,
  output logic [BEAT_W-1:0]     ld_val_o
);
  logic [BEAT_W-1:0] acc_mask;
  logic              sign_bit;

  assign acc_mask = ~({BEAT_W{1'b1}} << (6'd8 << acc_sh_i));
  assign wstrb_o  = ~({BEAT_BYTES{1'b1}} << (3'd1 << acc_sh_i));
  assign wdata_o  = src_lane_i & acc_mask;

  always_comb begin
    unique case (acc_sh_i)
      2'd0:    sign_bit = rdata_i[7];
      2'd1:    sign_bit = rdata_i[15];
      default: sign_bit = rdata_i[BEAT_W-1];
    endcase
  end

  assign ld_val_o = (rdata_i & acc_mask) | ((signed_i && sign_bit) ? ~acc_mask : '0);
endmodule

// File: rtl/vgs_seq.sv
module vgs_seq
  import vgs_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  load_i,
  input  logic                  signed_i,
  input  logic                  scale_i,
  input  logic [1:0]            esize_i,
  input  logic [1:0]            msize_i,
  input  logic [2:0]            dst_idx_i,
  input  logic [2:0]            off_idx_i,
  input  logic [3:0]            base_idx_i,
  input  logic [ADDR_W-1:0]     base_i,
  input  logic [VEC_W-1:0]      offs_i,
  input  logic [VEC_W-1:0]      data_i,
  input  logic [VEC_BYTES-1:0]  pred_i,
  input  logic [NBEATS-1:0]     beat_en_i,
  output logic                  mem_req_o,
  output logic                  mem_we_o,
  output logic [ADDR_W-1:0]     mem_addr_o,
  output logic [BEAT_W-1:0]     mem_wdata_o,
  output logic [BEAT_BYTES-1:0] mem_wstrb_o,
  input  logic                  mem_gnt_i,
  input  logic                  mem_rvalid_i,
  input  logic [BEAT_W-1:0]     mem_rdata_i,
  output logic                  done_o,
  output logic                  illegal_o,
  output logic [VEC_W-1:0]      result_o
);
  state_e state_q;
  logic                 dec_ill, dec_pair;
  logic [LANE_IW-1:0]   dec_last;
  logic [1:0]           dec_lane_sh, dec_acc_sh, dec_off_sh;

  logic                 ld_q, sgn_q, pair_q, ill_q;
  logic [1:0]           lane_sh_q, acc_sh_q, off_sh_q;
  logic [LANE_IW-1:0]   last_q, lane_q;
  logic [ADDR_W-1:0]    base_q;
  logic [VEC_W-1:0]     offs_q, res_q, merged;
  logic [VEC_BYTES-1:0] pred_q;
  logic [NBEATS-1:0]    beat_q;

  logic [LANE_IW-1:0]   pos;
  logic                 pred_on, beat_on, need_acc, zero_lane, adv, wr_en;
  logic [BEAT_W-1:0]    src_lane, ld_val, lane_wr_val;

  vgs_decode u_dec (
    .load_i     (load_i),
    .signed_i   (signed_i),
    .scale_i    (scale_i),
    .esize_i    (esize_i),
    .msize_i    (msize_i),
    .dst_idx_i  (dst_idx_i),
    .off_idx_i  (off_idx_i),
    .base_idx_i (base_idx_i),
    .illegal_o  (dec_ill),
    .last_lane_o(dec_last),
    .lane_sh_o  (dec_lane_sh),
    .acc_sh_o   (dec_acc_sh),
    .off_sh_o   (dec_off_sh),
    .pair_o     (dec_pair)
  );

  vgs_lane_sel u_lane (
    .lane_i    (lane_q),
    .lane_sh_i (lane_sh_q),
    .off_sh_i  (off_sh_q),
    .pair_i    (pair_q),
    .base_i    (base_q),
    .offs_i    (offs_q),
    .src_i     (res_q),
    .pred_i    (pred_q),
    .beat_en_i (beat_q),
    .pos_o     (pos),
    .addr_o    (mem_addr_o),
    .pred_on_o (pred_on),
    .beat_on_o (beat_on),
    .src_lane_o(src_lane)
  );

  vgs_access_fmt u_fmt (
    .acc_sh_i  (acc_sh_q),
    .signed_i  (sgn_q),
    .src_lane_i(src_lane),
    .rdata_i   (mem_rdata_i),
    .wdata_o   (mem_wdata_o),
    .wstrb_o   (mem_wstrb_o),
    .ld_val_o  (ld_val)
  );

  always_comb begin
    need_acc    = ld_q ? (beat_on & pred_on) : pred_on;
    zero_lane   = ld_q & beat_on & ~pred_on;
    adv         = 1'b0;
    wr_en       = 1'b0;
    lane_wr_val = ld_val;
    unique case (state_q)
      ST_ISSUE: begin
        if (!need_acc) begin
          adv         = 1'b1;
          wr_en       = zero_lane;
          lane_wr_val = '0;
        end else if (mem_gnt_i && !ld_q) begin
          adv = 1'b1;
        end
      end
      ST_WAIT: begin
        if (mem_rvalid_i) begin
          adv   = 1'b1;
          wr_en = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_comb begin
    merged = res_q;
    for (int b = 0; b < int'(VEC_BYTES); b++) begin
      if (b >= int'(pos) && b < int'(pos) + (1 << lane_sh_q))
        merged[b*8 +: 8] = lane_wr_val[(b - int'(pos))*8 +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      ld_q      <= 1'b0;
      sgn_q     <= 1'b0;
      pair_q    <= 1'b0;
      ill_q     <= 1'b0;
      lane_sh_q <= '0;
      acc_sh_q  <= '0;
      off_sh_q  <= '0;
      last_q    <= '0;
      lane_q    <= '0;
      base_q    <= '0;
      offs_q    <= '0;
      res_q     <= '0;
      pred_q    <= '0;
      beat_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            ld_q      <= load_i;
            sgn_q     <= signed_i;
            pair_q    <= dec_pair;
            ill_q     <= dec_ill;
            lane_sh_q <= dec_lane_sh;
            acc_sh_q  <= dec_acc_sh;
            off_sh_q  <= dec_off_sh;
            last_q    <= dec_last;
            lane_q    <= '0;
            base_q    <= base_i;
            offs_q    <= offs_i;
            res_q     <= data_i;
            pred_q    <= pred_i;
            beat_q    <= beat_en_i;
            state_q   <= dec_ill ? ST_DONE : ST_ISSUE;
          end
        end
        ST_ISSUE, ST_WAIT: begin
          if (wr_en) res_q <= merged;
          if (adv) begin
            lane_q  <= lane_q + 1'b1;
            state_q <= (lane_q == last_q) ? ST_DONE : ST_ISSUE;
          end else if (state_q == ST_ISSUE && need_acc && mem_gnt_i && ld_q) begin
            state_q <= ST_WAIT;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o = (state_q == ST_ISSUE) && need_acc;
  assign mem_we_o  = ~ld_q;
  assign done_o    = (state_q == ST_DONE);
  assign illegal_o = done_o && ill_q;
  assign result_o  = res_q;

  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_wdata_o)));

  // R9
  one_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_gnt_i && !mem_we_o) |=> !mem_req_o);

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  illegal_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && state_q == ST_IDLE && dec_ill) |=> (done_o && illegal_o && !mem_req_o));
endmodule

// File: tb/vgs_seq_test.sv
module vgs_seq_test;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic         load_i = 1'b0, signed_i = 1'b0, scale_i = 1'b0;
  logic [1:0]   esize_i = '0, msize_i = '0;
  logic [2:0]   dst_idx_i = '0, off_idx_i = '0;
  logic [3:0]   base_idx_i = '0;
  logic [31:0]  base_i = '0;
  logic [127:0] offs_i = '0, data_i = '0;
  logic [15:0]  pred_i = '0;
  logic [3:0]   beat_en_i = '0;
  logic         mem_req_o, mem_we_o;
  logic [31:0]  mem_addr_o, mem_wdata_o;
  logic [3:0]   mem_wstrb_o;
  logic         mem_gnt_i = 1'b0, mem_rvalid_i = 1'b0;
  logic [31:0]  mem_rdata_i = '0;
  logic         done_o, illegal_o;
  logic [127:0] result_o;

  typedef struct {
    bit        we;
    bit [31:0] addr;
    bit [31:0] wdata;
    bit [3:0]  wstrb;
  } acc_t;

  acc_t exp_q[$];
  int checks = 0, fails = 0, cyc = 0, pend = 0;
  bit [31:0] rd_hold;

  always #10 clk_i = ~clk_i;

  vgs_seq uut (.*);

  function automatic bit [7:0] mbyte(input bit [31:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ 8'hC3;
  endfunction

  function automatic bit [31:0] mword(input bit [31:0] a);
    return {mbyte(a + 3), mbyte(a + 2), mbyte(a + 1), mbyte(a)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory model and per-access comparison against the reference queue
  always @(negedge clk_i) begin
    cyc++;
    mem_rvalid_i = 1'b0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        mem_rvalid_i = 1'b1;
        mem_rdata_i  = rd_hold;
      end
    end
    mem_gnt_i = (cyc % 3) != 1;
    if (mem_req_o && mem_gnt_i) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R1", "unexpected access addr", 128'(mem_addr_o), 128'h0);
      end else begin
        acc_t e;
        e = exp_q.pop_front();
        chk(mem_we_o == e.we, "R1", "access kind", 128'(mem_we_o), 128'(e.we));
        chk(mem_addr_o == e.addr, "R2", "address", 128'(mem_addr_o), 128'(e.addr));
        chk(mem_wstrb_o == e.wstrb, "R7", "strobe", 128'(mem_wstrb_o), 128'(e.wstrb));
        if (e.we)
          chk(mem_wdata_o == e.wdata, "R7", "write data", 128'(mem_wdata_o), 128'(e.wdata));
      end
      if (!mem_we_o) begin
        pend    = 1 + (cyc % 2);
        rd_hold = mword(mem_addr_o);
      end
    end
  end

  task automatic run_op(input bit ld, input bit sg, input bit sc,
                        input bit [1:0] es, input bit [1:0] ms,
                        input bit [2:0] dq, input bit [2:0] oq, input bit [3:0] bq,
                        input bit [31:0] base, input bit [127:0] offs, input bit [127:0] dat,
                        input bit [15:0] pr, input bit [3:0] bt,
                        input string req, input bit poke);
    bit ill;
    bit [127:0] exp_res;
    int nl, eb, mb, shv, n;
    ill = (ms > es) || ((ms == 3) != (es == 3)) || (sg && (!ld || ms >= es)) ||
          (sc && ms == 0) || (ld && dq == oq) || (bq == 15);
    exp_res = dat;
    if (!ill) begin
      nl  = (es == 3) ? 4 : (16 >> es);
      eb  = (es == 3) ? 4 : (1 << es);
      mb  = (ms == 3) ? 4 : (1 << ms);
      shv = sc ? int'(ms) : 0;
      for (int e = 0; e < nl; e++) begin
        int p, ob;
        bit [31:0] off, addr;
        longint v;
        acc_t a;
        p = e * eb;
        if (ld && !bt[p / 4]) continue;
        ob = (es == 3) ? (e & ~1) * 4 : p;
        off = 0;
        for (int k = 0; k < eb; k++) off |= 32'(offs[(ob + k) * 8 +: 8]) << (8 * k);
        addr = base + (off << shv) + (((es == 3) && (e % 2 == 1)) ? 32'd4 : 32'd0);
        if (!pr[p]) begin
          if (ld) for (int k = 0; k < eb; k++) exp_res[(p + k) * 8 +: 8] = 8'h00;
          continue;
        end
        a.we = !ld;
        a.addr = addr;
        a.wstrb = 4'((1 << mb) - 1);
        v = 0;
        if (!ld) begin
          for (int k = 0; k < mb; k++) v |= longint'(dat[(p + k) * 8 +: 8]) << (8 * k);
          a.wdata = 32'(v);
        end else begin
          a.wdata = 0;
          for (int k = 0; k < mb; k++) v |= longint'(mbyte(addr + 32'(k))) << (8 * k);
          if (sg && v[mb * 8 - 1]) v |= ~((64'd1 << (mb * 8)) - 1);
          for (int k = 0; k < eb; k++) exp_res[(p + k) * 8 +: 8] = 8'(v >> (8 * k));
        end
        exp_q.push_back(a);
      end
    end
    load_i = ld; signed_i = sg; scale_i = sc; esize_i = es; msize_i = ms;
    dst_idx_i = dq; off_idx_i = oq; base_idx_i = bq; base_i = base;
    offs_i = offs; data_i = dat; pred_i = pr; beat_en_i = bt;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    if (poke) begin
      // R10: second start during the run must be ignored
      data_i = ~dat; offs_i = ~offs; start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    n = 0;
    while (!done_o && n < 2000) begin
      @(negedge clk_i);
      n++;
    end
    chk(done_o == 1'b1, "R10", {req, " completion"}, 128'(done_o), 128'h1);
    chk(illegal_o == ill, "R8", {req, " illegal flag"}, 128'(illegal_o), 128'(ill));
    chk(result_o == exp_res, req, "result vector", result_o, exp_res);
    chk(exp_q.size() == 0, "R1", {req, " missing accesses"}, 128'(exp_q.size()), 128'h0);
    exp_q.delete();
    @(negedge clk_i);
    chk(done_o == 1'b0, "R10", {req, " done pulse width"}, 128'(done_o), 128'h0);
  endtask

  localparam bit [127:0] OFFS_A = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0;
  localparam bit [127:0] OFFS_B = 128'h00000010_00000100_00000003_0000FFF0;
  localparam bit [127:0] DAT_A  = 128'hDEADBEEF_CAFEF00D_01234567_89ABCDEF;

  initial begin
    repeat (200000) @(posedge clk_i);
    chk(1'b0, "R10", "watchdog expired", 128'h0, 128'h1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R10 reset state
    chk(done_o == 1'b0 && illegal_o == 1'b0, "R10", "reset flags", 128'({done_o, illegal_o}), 128'h0);
    chk(mem_req_o == 1'b0, "R10", "reset request", 128'(mem_req_o), 128'h0);
    chk(result_o == '0, "R10", "reset result", result_o, 128'h0);

    // R1 R2 byte lanes, unsigned byte load
    run_op(1, 0, 0, 2'd0, 2'd0, 3'd1, 3'd2, 4'd3, 32'h1000_0000, OFFS_A, DAT_A, 16'hFFFF, 4'hF, "R1", 0);
    // R3 signed byte into halfword lanes
    run_op(1, 1, 0, 2'd1, 2'd0, 3'd1, 3'd2, 4'd3, 32'h2000_0040, OFFS_A, DAT_A, 16'hFFFF, 4'hF, "R3", 0);
    // R3 unsigned halfword into word lanes, scaled
    run_op(1, 0, 1, 2'd2, 2'd1, 3'd0, 3'd5, 4'd0, 32'h0000_8000, OFFS_B, DAT_A, 16'hFFFF, 4'hF, "R3", 0);
    // R3 signed halfword into word lanes
    run_op(1, 1, 0, 2'd2, 2'd1, 3'd0, 3'd5, 4'd0, 32'h0000_0081, OFFS_A, DAT_A, 16'hFFFF, 4'hF, "R3", 0);
    // R2 scaled word gather with base wrap
    run_op(1, 0, 1, 2'd2, 2'd2, 3'd3, 3'd4, 4'd7, 32'hFFFF_FF00, OFFS_B, DAT_A, 16'hFFFF, 4'hF, "R2", 0);
    // R4 predicated-off lanes zeroed
    run_op(1, 0, 0, 2'd1, 2'd1, 3'd3, 3'd4, 4'd7, 32'h0000_4000, OFFS_A, DAT_A, 16'h0F0F, 4'hF, "R4", 0);
    // R5 beat-disabled lanes keep value, mixed with predicate
    run_op(1, 0, 0, 2'd2, 2'd2, 3'd3, 3'd4, 4'd7, 32'h0000_4000, OFFS_B, DAT_A, 16'hF0FF, 4'b1010, "R5", 0);
    // R5 stores ignore beat enable
    run_op(0, 0, 0, 2'd2, 2'd2, 3'd3, 3'd3, 4'd7, 32'h0000_4000, OFFS_B, DAT_A, 16'hFFFF, 4'b0000, "R5", 0);
    // R6 doubleword gather, scaled, per-beat predicate
    run_op(1, 0, 1, 2'd3, 2'd3, 3'd2, 3'd6, 4'd1, 32'h0001_0000, OFFS_B, DAT_A, 16'h1101, 4'hF, "R6", 0);
    // R6 doubleword scatter, unscaled
    run_op(0, 0, 0, 2'd3, 2'd3, 3'd2, 3'd6, 4'd1, 32'h0001_0000, OFFS_A, DAT_A, 16'hFF0F, 4'h0, "R6", 0);
    // R7 byte stores from word lanes, and scaled halfword stores with predicate
    run_op(0, 0, 0, 2'd2, 2'd0, 3'd2, 3'd6, 4'd1, 32'h0002_0000, OFFS_A, DAT_A, 16'hFFFF, 4'hF, "R7", 0);
    run_op(0, 0, 1, 2'd1, 2'd1, 3'd2, 3'd6, 4'd1, 32'h0002_0000, OFFS_A, DAT_A, 16'h3C3C, 4'hF, "R7", 0);
    // R10 start while busy ignored
    run_op(1, 0, 0, 2'd0, 2'd0, 3'd1, 3'd2, 4'd3, 32'h3000_0000, OFFS_A, DAT_A, 16'hAAAA, 4'hF, "R10", 1);
    // R8 illegal encodings
    run_op(1, 0, 1, 2'd1, 2'd0, 3'd1, 3'd2, 4'd3, 32'h0, OFFS_A, DAT_A, 16'hFFFF, 4'hF, "R8", 0);
    run_op(1, 0, 0, 2'd2, 2'd2, 3'd4, 3'd4, 4'd3, 32'h0, OFFS_A, DAT_A, 16'hFFFF, 4'hF, "R8", 0);
    run_op(0, 0, 0, 2'd2, 2'd2, 3'd4, 3'd5, 4'd15, 32'h0, OFFS_A, DAT_A, 16'hFFFF, 4'hF, "R8", 0);
    run_op(1, 0, 0, 2'd1, 2'd2, 3'd1, 3'd2, 4'd3, 32'h0, OFFS_A, DAT_A, 16'hFFFF, 4'hF, "R8", 0);
    run_op(0, 0, 0, 2'd2, 2'd3, 3'd1, 3'd2, 4'd3, 32'h0, OFFS_A, DAT_A, 16'hFFFF, 4'hF, "R8", 0);
    run_op(1, 1, 0, 2'd1, 2'd1, 3'd1, 3'd2, 4'd3, 32'h0, OFFS_A, DAT_A, 16'hFFFF, 4'hF, "R8", 0);
    run_op(1, 0, 0, 2'd3, 2'd2, 3'd1, 3'd2, 4'd3, 32'h0, OFFS_A, DAT_A, 16'hFFFF, 4'hF, "R8", 0);
    run_op(0, 1, 0, 2'd2, 2'd0, 3'd1, 3'd2, 4'd3, 32'h0, OFFS_A, DAT_A, 16'hFFFF, 4'hF, "R8", 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule